// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers eight interrupt requests, three from pins and five from on-chip timers, into a bank of pending flags. Software can read and rewrite that bank. Each flag is masked by its own enable bit and by a global interrupt-enable flag. When at least one unmasked request is pending, the block selects a winner and emits a one-cycle accept strobe that carries the winner's index. That strobe is the point where a processor would begin saving its state and fetching the vector.

A 6-bit mode register sets the arbitration policy. Bits [5:4] select the mode: `00` is fixed order, `01` is fixed order with one favoured source, and `1x` blocks every acceptance. Bits [3:0] name the favoured source. Acceptance clears the global enable, so a second interrupt is taken only after software sets it again. This is how nesting is controlled.

Source indices are fixed as follows:

| Index | Source |
|---|---|
| 0 | tick timer |
| 1 | key scan |
| 2 | external line 1 |
| 3 | external line 2 |
| 4 | guard timer |
| 5 | timer 0 |
| 6 | timer 1 |
| 7 | timer 2 |

Top module: `prioIrqCtrl`

## Requirements
- R1: While reset is low, and directly after it, `flags`, `enables`, `modeReg`, `iFlag` and `acceptStb` are all zero.
- R2: A high bit k on `srcPulse` during a cycle makes `flags[k]` read 1 after the next rising edge.
- R3: With `flagWrEn` high, all flag bits take `flagWrData` at the edge, so bits can be set or cleared. A `srcPulse` bit in the same cycle still leaves its flag set.
- R4: A source is accepted only if all of these hold in the cycle before the strobe: its flag is 1, its enable bit is 1, `iFlag` is 1, and `modeReg[5]` is 0. `acceptStb` rises at the first edge after those conditions hold.
- R5: With `modeReg[5:4]`=00, the eligible source with the lowest index wins.
- R6: With `modeReg[5:4]`=01 and `modeReg[3]`=0, the source whose index equals `modeReg[2:0]` wins whenever it is eligible. The codes are 1 for key scan, 2 for line 1, 3 for line 2, and 5, 6 and 7 for timers 0 to 2. Otherwise the lowest eligible index wins, and this also applies when `modeReg[3]`=1.
- R7: With `modeReg[5]`=1, nothing is accepted and all pending flags are kept.
- R8: The edge that raises `acceptStb` also clears `iFlag` and the accepted flag, and `acceptStb` lasts exactly one cycle.
- R9: If a `srcPulse` bit for the accepted source arrives in the arbitration cycle, that flag stays set.
- R10: `iSet` sets `iFlag`, which re-enables acceptance (nesting). Both `iClr` and an acceptance override `iSet` in the same cycle.
- R11: With `modeWrEn` high, `modeReg` takes `modeWrData`. With `enWrEn` high, `enables` takes `enWrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | 8 | Request pulses, one per source |
| flagWrEn | input | 1 | Write strobe for the flag bank |
| flagWrData | input | 8 | New flag bank value |
| enWrEn | input | 1 | Write strobe for the enable bits |
| enWrData | input | 8 | New enable bits |
| modeWrEn | input | 1 | Write strobe for the mode register |
| modeWrData | input | 6 | New mode register value |
| iSet | input | 1 | Set the global enable |
| iClr | input | 1 | Clear the global enable |
| flags | output | 8 | Pending request flags |
| enables | output | 8 | Per-source enable bits |
| modeReg | output | 6 | Mode and favoured-source code |
| iFlag | output | 1 | Global interrupt enable |
| acceptStb | output | 1 | One-cycle acceptance strobe |
| acceptIdx | output | 3 | Index of the accepted source |

## Verification
Two functions can meet on one flag in the same cycle. Acceptance clears the winning flag, while a fresh request pulse, or a software write to the flag bank, sets it. Acceptance also meets a software `iSet` on the global enable. The bench provokes both collisions directly, by pulsing the source that is about to win and by raising `iSet` in the arbitration cycle. It also meets them at random during a long stimulus run. In every case a reference model of the requirements judges the flags, the global enable and the strobe one edge later.

// File: rtl/intcPkg.sv
package intcPkg;
  localparam int SRC_N     = 8;
  localparam int SRC_IDX_W = $clog2(SRC_N);
  localparam int PRIO_W    = 4;
  localparam int MODE_W    = 2;
  localparam int MREG_W    = MODE_W + PRIO_W;

  localparam logic [MODE_W-1:0] MODE_FIXED = 2'b00;
  localparam logic [MODE_W-1:0] MODE_PICK  = 2'b01;

  // strobe from arbitration control to the flag datapath
  typedef struct packed {
    logic                 take;
    logic [SRC_IDX_W-1:0] idx;
  } grant_t;
endpackage

// File: rtl/intcCtrl.sv
module intcCtrl
  import intcPkg::*;
#(
  parameter int NUM_SRC = SRC_N
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeWrEn,
  input  logic [MREG_W-1:0]  modeWrData,
  input  logic               iSet,
  input  logic               iClr,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] enMask,
  output logic [MREG_W-1:0]  modeReg,
  output logic               iFlag,
  output grant_t             grant
);
  localparam int IDX_W = SRC_IDX_W;

  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   lowIdx;
  logic [IDX_W-1:0]   prioSel;
  logic               pickValid;
  logic [MODE_W-1:0]  modeField;
  logic [PRIO_W-1:0]  prioCode;

  assign modeField = modeReg[MREG_W-1:PRIO_W];
  assign prioCode  = modeReg[PRIO_W-1:0];
  assign prioSel   = prioCode[IDX_W-1:0];

  always_comb begin
    eligible = pending & enMask;
    lowIdx   = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (eligible[k]) lowIdx = IDX_W'(k);
    end
    pickValid  = (modeField == MODE_PICK) && (int'(prioCode) < NUM_SRC)
                 && eligible[prioSel];
    grant.take = iFlag && !modeField[1] && (|eligible);
    grant.idx  = pickValid ? prioSel : lowIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      iFlag   <= 1'b0;
    end else begin
      if (modeWrEn) modeReg <= modeWrData;
      if (grant.take || iClr) iFlag <= 1'b0;
      else if (iSet)          iFlag <= 1'b1;
    end
  end

  p_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !iFlag |-> !grant.take);
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeField[1] |-> !grant.take);
  p_iflag_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    grant.take |=> !iFlag);
  p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grant.take && modeField == MODE_FIXED)
      |-> ((eligible & ~({NUM_SRC{1'b1}} << grant.idx)) == '0));
  p_pick_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grant.take && modeField == MODE_PICK && !prioCode[PRIO_W-1]
      && eligible[prioSel]) |-> (grant.idx == prioSel));
endmodule

// File: rtl/intcData.sv
module intcData
  import intcPkg::*;
#(
  parameter int NUM_SRC = SRC_N
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcPulse,
  input  logic                 flagWrEn,
  input  logic [NUM_SRC-1:0]   flagWrData,
  input  logic                 enWrEn,
  input  logic [NUM_SRC-1:0]   enWrData,
  input  grant_t               grant,
  output logic [NUM_SRC-1:0]   flags,
  output logic [NUM_SRC-1:0]   enables,
  output logic                 acceptStb,
  output logic [SRC_IDX_W-1:0] acceptIdx
);
  localparam int IDX_W = SRC_IDX_W;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    logic baseBit;
    logic clearBit;
    assign baseBit  = flagWrEn ? flagWrData[g] : flags[g];
    assign clearBit = grant.take && (grant.idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) flags[g] <= 1'b0;
      else       flags[g] <= (baseBit && !clearBit) || srcPulse[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enables   <= '0;
      acceptStb <= 1'b0;
      acceptIdx <= '0;
    end else begin
      if (enWrEn) enables <= enWrData;
      acceptStb <= grant.take;
      if (grant.take) acceptIdx <= grant.idx;
    end
  end

  p_flag_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    (grant.take && !srcPulse[grant.idx]) |=> !flags[$past(grant.idx)]);
  p_pulse_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (grant.take && srcPulse[grant.idx]) |=> flags[$past(grant.idx)]);
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |=> !acceptStb);
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|srcPulse) |=> ((flags & $past(srcPulse)) == $past(srcPulse)));
endmodule

// File: rtl/prioIrqCtrl.sv
module prioIrqCtrl
  import intcPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_N-1:0]     srcPulse,
  input  logic                 flagWrEn,
  input  logic [SRC_N-1:0]     flagWrData,
  input  logic                 enWrEn,
  input  logic [SRC_N-1:0]     enWrData,
  input  logic                 modeWrEn,
  input  logic [MREG_W-1:0]    modeWrData,
  input  logic                 iSet,
  input  logic                 iClr,
  output logic [SRC_N-1:0]     flags,
  output logic [SRC_N-1:0]     enables,
  output logic [MREG_W-1:0]    modeReg,
  output logic                 iFlag,
  output logic                 acceptStb,
  output logic [SRC_IDX_W-1:0] acceptIdx
);
  grant_t grant;

  intcCtrl #(.NUM_SRC(SRC_N)) uCtrl (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .iSet(iSet), .iClr(iClr),
    .pending(flags), .enMask(enables),
    .modeReg(modeReg), .iFlag(iFlag), .grant(grant)
  );

  intcData #(.NUM_SRC(SRC_N)) uData (
    .clk(clk), .rstN(rstN),
    .srcPulse(srcPulse),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .enWrEn(enWrEn), .enWrData(enWrData),
    .grant(grant),
    .flags(flags), .enables(enables),
    .acceptStb(acceptStb), .acceptIdx(acceptIdx)
  );
endmodule

// File: tb/tb_prioIrqCtrl.sv
module tb_prioIrqCtrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcPulse = '0, flagWrData = '0, enWrData = '0;
  logic       flagWrEn = 1'b0, enWrEn = 1'b0, modeWrEn = 1'b0;
  logic [5:0] modeWrData = '0;
  logic       iSet = 1'b0, iClr = 1'b0;
  logic [7:0] flags, enables;
  logic [5:0] modeReg;
  logic       iFlag, acceptStb;
  logic [2:0] acceptIdx;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [7:0] mF = '0, mE = '0;
  logic [5:0] mM = '0;
  logic       mI = 1'b0, eStb = 1'b0;
  logic [2:0] eIdx = '0;
  logic       eWasPick = 1'b0;

  always #2 clk = ~clk;

  prioIrqCtrl dut (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .enWrEn(enWrEn), .enWrData(enWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .iSet(iSet), .iClr(iClr),
    .flags(flags), .enables(enables), .modeReg(modeReg),
    .iFlag(iFlag), .acceptStb(acceptStb), .acceptIdx(acceptIdx)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // winner per requirements R5 and R6
  function automatic logic [2:0] pickWinner(logic [7:0] elig, logic [5:0] m);
    logic [2:0] w = 3'd0;
    for (int k = 7; k >= 0; k--) if (elig[k]) w = 3'(k);
    if (m[5:4] == 2'b01 && !m[3] && elig[m[2:0]]) w = m[2:0];
    return w;
  endfunction

  task automatic cycle(logic [7:0] pulse, logic fw, logic [7:0] fwd,
                       logic ew, logic [7:0] ewd, logic mw, logic [5:0] mwd,
                       logic is, logic ic);
    logic [7:0] elig;
    logic       take;
    logic [2:0] w;
    srcPulse = pulse; flagWrEn = fw; flagWrData = fwd;
    enWrEn = ew; enWrData = ewd; modeWrEn = mw; modeWrData = mwd;
    iSet = is; iClr = ic;
    @(posedge clk);
    elig = mF & mE;
    take = mI && !mM[5] && (elig != 0);
    w    = pickWinner(elig, mM);
    eWasPick = (mM[5:4] == 2'b01);
    mF = (fw ? fwd : mF);
    if (take) mF[w] = 1'b0;
    mF = mF | pulse;
    if (ew) mE = ewd;
    if (mw) mM = mwd;
    if (take || ic) mI = 1'b0; else if (is) mI = 1'b1;
    eStb = take;
    if (take) eIdx = w;
    @(negedge clk);
    chk("R2 flags", flags, mF);
    chk("R11 enables", enables, mE);
    chk("R11 mode", modeReg, mM);
    chk("R8 iFlag", iFlag, mI);
    chk("R4 strobe", acceptStb, eStb);
    if (eStb) chk(eWasPick ? "R6 index" : "R5 index", acceptIdx, eIdx);
  endtask

  task automatic idle();
    cycle('0, 0, '0, 0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 enables", enables, 0);
    chk("R1 mode", modeReg, 0);
    chk("R1 iFlag", iFlag, 0);
    chk("R1 strobe", acceptStb, 0);
    rstN = 1'b1;

    // R5 fixed order: lowest of 2,5,7
    cycle(8'hA4, 0, '0, 1, 8'hFF, 0, '0, 1, 0);
    idle();
    chk("R5 strobe", acceptStb, 1);
    chk("R5 idx", acceptIdx, 2);
    idle();
    chk("R8 iFlag cleared", iFlag, 0);
    chk("R8 flag cleared", flags, 8'hA0);
    chk("R8 one-cycle strobe", acceptStb, 0);
    // R10 nesting: re-enable, next winner taken
    cycle('0, 0, '0, 0, '0, 0, '0, 1, 0);
    idle();
    chk("R10 nested accept idx", acceptIdx, 5);
    chk("R10 nested strobe", acceptStb, 1);

    // R6 favoured source 7 beats 0 and 1
    cycle(8'h03, 0, '0, 0, '0, 1, 6'b01_0111, 1, 0);
    idle();
    chk("R6 favoured strobe", acceptStb, 1);
    chk("R6 favoured idx", acceptIdx, 7);
    cycle('0, 0, '0, 0, '0, 0, '0, 1, 0);
    idle();
    chk("R6 fallback idx", acceptIdx, 0);

    // R7 inhibit
    cycle(8'h10, 0, '0, 0, '0, 1, 6'b10_0000, 1, 0);
    repeat (3) begin
      idle();
      chk("R7 no strobe", acceptStb, 0);
    end
    chk("R7 flags kept", flags, 8'h12);

    // R9 pulse on winner in arbitration cycle
    cycle('0, 0, '0, 0, '0, 1, 6'b00_0000, 0, 0);
    cycle(8'h02, 0, '0, 0, '0, 0, '0, 0, 0);
    chk("R9 strobe", acceptStb, 1);
    chk("R9 idx", acceptIdx, 1);
    chk("R9 flag kept", flags[1], 1);

    // R3 write plus simultaneous pulse
    cycle(8'h01, 1, 8'h40, 0, '0, 0, '0, 0, 0);
    chk("R3 flags", flags, 8'h41);
    // R4 enables cleared blocks acceptance
    cycle('0, 0, '0, 1, 8'h00, 0, '0, 1, 0);
    idle();
    chk("R4 masked no strobe", acceptStb, 0);
    // R10 acceptance beats iSet
    cycle('0, 0, '0, 1, 8'hFF, 0, '0, 0, 0);
    cycle('0, 0, '0, 0, '0, 0, '0, 1, 0);
    chk("R10 accept over set strobe", acceptStb, 1);
    chk("R10 accept over set iFlag", iFlag, 0);
    // R10 iClr beats iSet
    cycle('0, 0, '0, 0, '0, 0, '0, 1, 1);
    chk("R10 clear over set", iFlag, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] p;
      p = 8'($urandom & $urandom & $urandom);
      cycle(p,
            ($urandom % 16) == 0, 8'($urandom),
            ($urandom % 16) == 0, 8'($urandom),
            ($urandom % 12) == 0, 6'($urandom),
            ($urandom % 4) == 0, ($urandom % 16) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule